// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps wall-clock time as a 32-bit count of whole seconds, paced by a slow crystal input sampled on the system clock. The oscillator input passes through a small synchroniser, and every rising edge found there advances a divider. When the divider reaches a programmable terminal value, one seconds tick is produced. A 5-bit trim value lengthens chosen seconds by one oscillator cycle. This corrects a crystal that runs fast or slow by a fraction of a cycle per second, spread over a 16-second frame.

Software sets the time through a staging register. The staged value is not visible as the current time straight away. It is loaded on the next seconds tick, and each tick also raises a seconds event flag. Until that flag is seen, software reads the staged value back to learn the time it just programmed. Writing the calibration word restarts the divider, so a calibration write followed by a set-time write lines the following tick up exactly one programmed second later. A control register holds one read/write enable bit that asks the power logic to fall back to a battery supply.

Top module: `rtc_seconds_top`

## Requirements
- R1: Register offsets (byte addresses on the 7-bit bus): 0x00 set-time write, 0x04 set-time readback, 0x08 calibration, 0x10 current time, 0x20 status, 0x40 control. After reset the current time, the staged time, the status and the control read 0, and the calibration reads 0x198233. Reads of 0x00 and of unmapped offsets return 0.
- R2: The calibration word keeps bits 20:0 of the written data and discards every bit above bit 20. Offset 0x08 reads back the kept 21 bits, zero-extended.
- R3: Calibration bits 15:0 give the terminal count TC, and an unstretched second lasts TC+1 counted oscillator rising edges. The oscillator input passes a two-stage synchroniser, so a rising edge first sampled at clock edge k is counted at clock edge k+2.
- R4: Calibration bits 20:16 give the trim N. Seconds are numbered 0 to 15 within a repeating 16-second frame, and seconds whose number is below N last one extra oscillator edge. A trim of 16 or more stretches every second.
- R5: A write to the calibration register clears the divider and restarts the frame at second 0, and no tick is produced on the cycle of that write. With trim 0 the next tick therefore comes on the (TC+1)th counted oscillator edge after the write.
- R6: A write to offset 0x00 leaves the current time unchanged. Offset 0x04 returns the written value from the following cycle on.
- R7: On a tick the current time is loaded with the staged value if a set-time write is pending; otherwise it increments by one. The pending state clears on the load.
- R8: A set-time write on the same cycle as a tick does not take part in that tick. The tick uses the earlier state, and the new value stays pending for the next tick.
- R9: Status bit 0 is the seconds flag. It is set by every tick, and the output sec_irq_o follows it.
- R10: Writing status data with bit 0 at 1 clears the flag, and writing bit 0 at 0 has no effect. A clear on the same cycle as a tick leaves the flag set.
- R11: Control bit 31 is read/write and drives batt_sw_en_o. Control bits 30:0 read 0.
- R12: Writes to the read-only offsets 0x04 and 0x10 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_clk_i | input | 1 | Slow crystal oscillator input, asynchronous to clk |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 7 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| sec_irq_o | output | 1 | Seconds event flag |
| batt_sw_en_o | output | 1 | Battery fallback enable |

## Verification
The hardest cases are a register write that lands on exactly the clock edge where a tick fires. This applies both to the flag clear and to a new set-time value, and the bus alone gives no way to see when that edge comes. The bench runs the oscillator continuously and tracks the synchroniser and divider state in its reference model. On each falling clock edge it asks the model whether the next rising edge will tick, and issues the write in that same half-cycle. Trim is checked by measuring clock cycles between successive flag rises across more than one full 16-second frame.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int TC_W    = 16;
    localparam int TRIM_W  = 5;
    localparam int CAL_W   = TC_W + TRIM_W;
    localparam int FRAME_W = 4;

    localparam logic [ADDR_W-1:0] OFF_SET_WR = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_SET_RD = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_CAL    = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_TIME   = 7'h10;
    localparam logic [ADDR_W-1:0] OFF_STS    = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 7'h40;

    localparam int BATT_BIT = 31;

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic [TC_W-1:0]   tc;
    } cal_t;

    localparam cal_t CAL_RESET = cal_t'(21'h198233);

    function automatic cal_t cal_from_word(input logic [DATA_W-1:0] w);
        return cal_t'(w[CAL_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] cal_to_word(input cal_t c);
        return {{(DATA_W-CAL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/rtc_osc_sync.sv
module rtc_osc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_i,
    output logic edge_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], osc_i};
    end

    assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_pkg::*;
#(
    parameter int CNT_W = TC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_edge,
    input  logic             restart,
    input  cal_t             cal,
    output logic             tick,
    output logic [CNT_W-1:0] div_cnt
);
    logic [FRAME_W-1:0] frame_q;
    logic               stretch;
    logic [CNT_W-1:0]   limit;

    assign stretch = (32'(frame_q) < 32'(cal.trim));
    assign limit   = CNT_W'(cal.tc) + CNT_W'(stretch);
    assign tick    = osc_edge & ~restart & (div_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            frame_q <= '0;
        end else if (restart) begin
            div_cnt <= '0;
            frame_q <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            frame_q <= frame_q + 1'b1;
        end else if (osc_edge) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_val,
    input  logic              clr_flag,
    output logic [DATA_W-1:0] cur_time,
    output logic [DATA_W-1:0] stage_q,
    output logic              pend_q,
    output logic              flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_time <= '0;
            stage_q  <= '0;
            pend_q   <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (tick) cur_time <= pend_q ? stage_q : cur_time + 1'b1;

            if (set_we)    pend_q <= 1'b1;
            else if (tick) pend_q <= 1'b0;

            if (set_we) stage_q <= set_val;

            if (tick)          flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_seconds_top.sv
module rtc_seconds_top
    import rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_clk_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sec_irq_o,
    output logic              batt_sw_en_o
);
    localparam int CNT_W = TC_W + 1;

    logic              wr_en, set_we, cal_we, ctrl_we, sts_w1c;
    logic              osc_edge, tick;
    logic [CNT_W-1:0]  div_cnt;
    cal_t              cal_q;
    logic              batt_q;
    logic [DATA_W-1:0] cur_time, stage_q;
    logic              pend_q, flag_q;

    assign wr_en   = bus_sel_i & bus_we_i;
    assign set_we  = wr_en & (bus_addr_i == OFF_SET_WR);
    assign cal_we  = wr_en & (bus_addr_i == OFF_CAL);
    assign ctrl_we = wr_en & (bus_addr_i == OFF_CTRL);
    assign sts_w1c = wr_en & (bus_addr_i == OFF_STS) & bus_wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q  <= CAL_RESET;
            batt_q <= 1'b0;
        end else begin
            if (cal_we)  cal_q  <= cal_from_word(bus_wdata_i);
            if (ctrl_we) batt_q <= bus_wdata_i[BATT_BIT];
        end
    end

    rtc_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .osc_i  (osc_clk_i),
        .edge_o (osc_edge)
    );

    rtc_tick_gen #(.CNT_W(CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .osc_edge (osc_edge),
        .restart  (cal_we),
        .cal      (cal_q),
        .tick     (tick),
        .div_cnt  (div_cnt)
    );

    rtc_time_core u_time (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .set_we   (set_we),
        .set_val  (bus_wdata_i),
        .clr_flag (sts_w1c),
        .cur_time (cur_time),
        .stage_q  (stage_q),
        .pend_q   (pend_q),
        .flag_q   (flag_q)
    );

    always_comb begin
        case (bus_addr_i)
            OFF_SET_RD: bus_rdata_o = stage_q;
            OFF_CAL:    bus_rdata_o = cal_to_word(cal_q);
            OFF_TIME:   bus_rdata_o = cur_time;
            OFF_STS:    bus_rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
            OFF_CTRL:   bus_rdata_o = {batt_q, {(DATA_W-1){1'b0}}};
            default:    bus_rdata_o = '0;
        endcase
    end

    assign sec_irq_o    = flag_q;
    assign batt_sw_en_o = batt_q;
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W = TC_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              cal_we,
    input logic              ctrl_we,
    input logic              sts_w1c,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cur_time,
    input logic [DATA_W-1:0] stage_q,
    input logic              pend_q,
    input logic              flag_q,
    input logic              batt_q,
    input logic [CNT_W-1:0]  div_cnt,
    input cal_t              cal_q
);
    // R7: plain increment when nothing is staged
    a_r7_increment: assert property (@(posedge clk) disable iff (rst)
        tick && !pend_q |=> cur_time == $past(cur_time) + 1);

    // R7: staged value is loaded on the tick
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        tick && pend_q |=> cur_time == $past(stage_q));

    // R6: the current time moves only on a tick
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cur_time));

    // R10: a tick always leaves the flag set
    a_r10_tick_wins: assert property (@(posedge clk) disable iff (rst)
        tick |=> flag_q);

    // R10: a clear without a tick drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        sts_w1c && !tick |=> !flag_q);

    // R5: calibration write restarts the divider and suppresses the tick
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        cal_we |=> div_cnt == '0);
    a_r5_no_tick: assert property (@(posedge clk) disable iff (rst)
        cal_we |-> !tick);

    // R3: divider never passes its stretched limit
    a_r3_bound: assert property (@(posedge clk) disable iff (rst)
        32'(div_cnt) <= 32'(cal_q.tc) + 1);

    // R11: battery enable follows control writes
    a_r11_batt: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> batt_q == $past(wdata[BATT_BIT]));
endmodule

bind rtc_seconds_top rtc_seconds_chk #(.CNT_W(rtc_pkg::TC_W + 1)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cal_we   (cal_we),
    .ctrl_we  (ctrl_we),
    .sts_w1c  (sts_w1c),
    .wdata    (bus_wdata_i),
    .cur_time (cur_time),
    .stage_q  (stage_q),
    .pend_q   (pend_q),
    .flag_q   (flag_q),
    .batt_q   (batt_q),
    .div_cnt  (div_cnt),
    .cal_q    (cal_q)
);

// File: tb/rtc_seconds_top_tb.sv
`timescale 1ns/100ps
module rtc_seconds_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc = 1'b0;
    logic        sel = 1'b0;
    logic        we  = 1'b0;
    logic [6:0]  addr = 7'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, batt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit osc_run = 1'b0;

    rtc_seconds_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .osc_clk_i    (osc),
        .bus_sel_i    (sel),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .sec_irq_o    (irq),
        .batt_sw_en_o (batt)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) if (osc_run) osc <= ~osc;
    always @(posedge clk) cyc++;

    // ---------------- behavioural reference model ----------------
    int unsigned m_cur, m_stage, m_cal;
    bit          m_pend, m_flag, m_batt;
    int          m_cnt, m_per;
    bit          h1, h2, h3;

    function automatic int m_lim();
        int trim;
        trim = int'((m_cal >> 16) & 32'h1F);
        return int'(m_cal & 32'hFFFF) + ((m_per < trim) ? 1 : 0);
    endfunction

    function automatic bit m_tick_next();
        return h2 && !h3 && (m_cnt >= m_lim());
    endfunction

    function automatic logic [31:0] m_read(input logic [6:0] a);
        case (a)
            7'h04:   return m_stage;
            7'h08:   return m_cal;
            7'h10:   return m_cur;
            7'h20:   return {31'd0, m_flag};
            7'h40:   return {m_batt, 31'd0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit pulse, calw, tk, opend;
        int unsigned ostage;
        if (rst) begin
            m_cur = 0; m_stage = 0; m_cal = 32'h198233;
            m_pend = 0; m_flag = 0; m_batt = 0;
            m_cnt = 0; m_per = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            pulse  = h2 && !h3;
            calw   = sel && we && addr == 7'h08;
            tk     = pulse && !calw && (m_cnt >= m_lim());
            opend  = m_pend;
            ostage = m_stage;
            if (calw)       begin m_cnt = 0; m_per = 0; end
            else if (tk)    begin m_cnt = 0; m_per = (m_per + 1) % 16; end
            else if (pulse) m_cnt++;
            if (tk) begin
                if (opend) begin m_cur = ostage; m_pend = 0; end
                else m_cur++;
                m_flag = 1;
            end else if (sel && we && addr == 7'h20 && wdata[0]) begin
                m_flag = 0;
            end
            if (sel && we && addr == 7'h00) begin m_stage = wdata; m_pend = 1; end
            if (calw) m_cal = wdata & 32'h1FFFFF;
            if (sel && we && addr == 7'h40) m_batt = wdata[31];
            h3 = h2; h2 = h1; h1 = osc;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk(irq == m_flag, "R9/R10 seconds flag", 32'(irq), 32'(m_flag));
            chk(batt == m_batt, "R11 battery enable", 32'(batt), 32'(m_batt));
            chk(rdata == m_read(addr), "R1 read data vs model", rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0; addr = 7'h10;
    endtask

    // drive at the current falling edge, release at the next
    task automatic wr_now(input logic [6:0] a, input logic [31:0] d);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0; addr = 7'h10;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #0.5;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    // clear the flag, then wait for the next rise; returns the cycle it was seen
    task automatic wait_tick(output int at);
        wr(7'h20, 32'h1);
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1;
            if (irq) begin at = cyc; break; end
        end
        chk(at >= 0, "R9 tick expected", 32'(at), 32'd0);
    endtask

    task automatic wait_collision();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (m_tick_next()) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        int t, prev, n;
        logic [31:0] snap;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset values and map
        rd(7'h10, 32'h0, "R1 time after reset");
        rd(7'h04, 32'h0, "R1 staged after reset");
        rd(7'h08, 32'h198233, "R1 calibration after reset");
        rd(7'h20, 32'h0, "R1 status after reset");
        rd(7'h40, 32'h0, "R1 control after reset");
        rd(7'h00, 32'h0, "R1 write-only offset reads 0");
        rd(7'h3C, 32'h0, "R1 unmapped offset reads 0");

        // R2 masking
        wr(7'h08, 32'hFFE0_0003);
        rd(7'h08, 32'h0000_0003, "R2 bits above 20 dropped");

        // R12 read-only writes ignored
        wr(7'h10, 32'hDEAD_BEEF);
        wr(7'h04, 32'h1234_5678);
        rd(7'h10, 32'h0, "R12 time unchanged");
        rd(7'h04, 32'h0, "R12 staged unchanged");

        osc_run = 1;
        repeat (10) @(negedge clk);

        // R5 / R3: second length after calibration write (TC=3, 4 edges)
        wr(7'h08, 32'h3);
        wr(7'h20, 32'h1);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1; n++;
            if (irq) break;
        end
        chk(n == 7 || n == 8, "R5/R3 cycles from calibration to tick", 32'(n), 32'd8);

        // R6 / R7 staged set-time
        snap = m_cur;
        wr(7'h00, 32'd1000);
        rd(7'h10, snap, "R6 time not yet changed");
        rd(7'h04, 32'd1000, "R6 readback of staged value");
        wait_tick(t);
        rd(7'h10, 32'd1000, "R7 staged value loaded on tick");
        wait_tick(t);
        rd(7'h10, 32'd1001, "R7 increment after load");

        // R10 write-1-to-clear
        rd(7'h20, 32'h1, "R9 flag set after tick");
        wr(7'h20, 32'h0);
        rd(7'h20, 32'h1, "R10 writing 0 leaves flag");
        wr(7'h20, 32'h1);
        rd(7'h20, 32'h0, "R10 writing 1 clears flag");

        // R10 clear colliding with a tick
        wait_collision();
        wr_now(7'h20, 32'h1);
        rd(7'h20, 32'h1, "R10 tick wins over clear");

        // R8 set-time colliding with a tick
        wait_collision();
        snap = m_cur;
        wr_now(7'h00, 32'd5000);
        rd(7'h10, snap + 1, "R8 colliding tick uses old state");
        wait_tick(t);
        rd(7'h10, 32'd5000, "R8 new value loaded on following tick");

        // R4 trim 3, TC 2: seconds 0..2 last 8 cycles, others 6
        wr(7'h08, 32'h0003_0002);
        wait_tick(prev);
        for (int k = 1; k <= 17; k++) begin
            wait_tick(t);
            chk(t - prev == ((k % 16) < 3 ? 8 : 6), "R4 stretched second length",
                32'(t - prev), ((k % 16) < 3) ? 32'd8 : 32'd6);
            prev = t;
        end

        // R4 trim of 20 stretches every second
        wr(7'h08, 32'h0014_0002);
        wait_tick(prev);
        for (int k = 1; k <= 18; k++) begin
            wait_tick(t);
            chk(t - prev == 8, "R4 trim above 15 stretches all", 32'(t - prev), 32'd8);
            prev = t;
        end

        // R11 control
        wr(7'h40, 32'h8000_0000);
        rd(7'h40, 32'h8000_0000, "R11 enable bit set");
        chk(batt == 1'b1, "R11 enable output high", 32'(batt), 32'd1);
        wr(7'h40, 32'h7FFF_FFFF);
        rd(7'h40, 32'h0, "R11 enable cleared, low bits read 0");
        chk(batt == 1'b0, "R11 enable output low", 32'(batt), 32'd0);

        repeat (20) @(negedge clk);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule